// File: doc/BRIEF.md
# GPIO Bank with Per-Write Bit Enables

A 32-pin general-purpose I/O bank controlled over a simple 32-bit register bus. Software sets the level that each pin drives and the pin's direction. It can also read back the synchronised level present on every pin, and a constant identifier that tells software which register layout the bank uses.

The output-level and direction registers are each split into two 16-pin halves. Pins 0-15 sit in a low word and pins 16-31 in the word directly above it. On every write to a half, the upper 16 bits of the bus data act as per-bit enables for the lower 16 bits. A single bus write can therefore set or clear any subset of pins without first reading the register. Two agents that touch different pins never need a lock.

Reads are combinational from the address. A write strobe is sampled on the rising clock edge, and the new value is visible on the pads and on the bus right after that edge.

Top module: `gpio_mwr_bank`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears every output-level and direction bit, so pad_oe_o and pad_out_o are all zero and every pin is an input.
- R2: In a write to a half register, data bit n (0..15) is loaded only when bit 16+n of the write is 1. Otherwise bit n keeps its value.
- R3: Pin p lives in the half at base + 4*(p >> 4), at bit p & 15. Output-level halves are at 0x00 (pins 0-15) and 0x04 (pins 16-31). Direction halves are at 0x08 and 0x0C. A write to one half leaves the other half unchanged.
- R4: pad_oe_o[p] is 1 exactly when the direction bit of pin p is 1 (1 = output, 0 = input). pad_out_o[p] carries the stored output level of pin p.
- R5: A read of a half register returns its 16 stored bits in bits 15:0 and zero in bits 31:16.
- R6: A read at 0x70 returns one bit per pin. Bit p is the level of pin p after a two-flop synchroniser, visible after the second rising edge following an input change. For a pin whose direction is output, that level is the driven value rather than pad_in_i.
- R7: Writes to 0x70, to 0x78 or to any unmapped address change no register, pad output or read value.
- R8: A read at 0x78 returns 0x0101157C.
- R9: A read of any address other than 0x00, 0x04, 0x08, 0x0C, 0x70 and 0x78 returns zero.
- R10: A write strobe sampled at a rising edge updates the register and the pads right after that edge, and the new value holds until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data: enables in 31:16, values in 15:0 |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pad_in_i | input | 32 | Asynchronous pin input levels |
| pad_out_o | output | 32 | Output level per pin |
| pad_oe_o | output | 32 | Output enable per pin (1 = drive) |

## Verification
The bench writes enable patterns that select scattered bits: a single cleared bit, a nibble inside a half, and masks with mixed ones and zeros. A design that ignored the enables, or took them from the wrong half of the word, would change neighbouring pins and the per-cycle model would flag pad_out_o. Writes to each half are followed by checks on the other half, which catches a wrong pin-to-half split. The input-level register is sampled one and two edges after an input change, so a synchroniser with one stage too many or too few is caught. Pins configured as outputs must report their driven value. Writes to the read-only and unmapped addresses, and reads of holes in the map, must leave the pads unchanged and return zero.

// File: rtl/gpio_mwr_pkg.sv
package gpio_mwr_pkg;
  localparam int unsigned OUT_BASE   = 32'h00;
  localparam int unsigned DIR_BASE   = 32'h08;
  localparam int unsigned LEVEL_ADDR = 32'h70;
  localparam int unsigned IDENT_ADDR = 32'h78;
  localparam logic [31:0] IDENT_VAL  = 32'h0101_157C;
endpackage

// File: rtl/gpio_half_reg.sv
module gpio_half_reg #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0]   q_o
);
  logic [HALF_W-1:0] en, val;
  assign en  = wdata_i[2*HALF_W-1:HALF_W];
  assign val = wdata_i[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= (q_o & ~en) | (val & en);
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_mwr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned BUS_W    = 2 * HALF_W,
  localparam int unsigned NUM_HALF = NUM_PINS / HALF_W
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic [BUS_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (addr_i == ADDR_W'(OUT_BASE + 4 * h))
        rdata_o[HALF_W-1:0] = out_i[h*HALF_W +: HALF_W];
      if (addr_i == ADDR_W'(DIR_BASE + 4 * h))
        rdata_o[HALF_W-1:0] = dir_i[h*HALF_W +: HALF_W];
    end
    if (addr_i == ADDR_W'(LEVEL_ADDR)) rdata_o = BUS_W'(lvl_i);
    if (addr_i == ADDR_W'(IDENT_ADDR)) rdata_o = BUS_W'(IDENT_VAL);
  end
endmodule

// File: rtl/gpio_mwr_bank.sv
module gpio_mwr_bank
  import gpio_mwr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned BUS_W    = 2 * HALF_W,
  localparam int unsigned NUM_HALF = NUM_PINS / HALF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BUS_W-1:0]    bus_wdata_i,
  output logic [BUS_W-1:0]    bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  logic [NUM_PINS-1:0] out_q, dir_q, lvl_raw, lvl_q;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic wr_out, wr_dir;
    assign wr_out = bus_we_i && (bus_addr_i == ADDR_W'(OUT_BASE + 4 * h));
    assign wr_dir = bus_we_i && (bus_addr_i == ADDR_W'(DIR_BASE + 4 * h));

    gpio_half_reg #(.HALF_W(HALF_W)) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_out),
      .wdata_i(bus_wdata_i), .q_o(out_q[h*HALF_W +: HALF_W]));
    gpio_half_reg #(.HALF_W(HALF_W)) u_dir (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_dir),
      .wdata_i(bus_wdata_i), .q_o(dir_q[h*HALF_W +: HALF_W]));
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q;

  // output pins report the value being driven
  assign lvl_raw = (dir_q & out_q) | (~dir_q & pad_in_i);

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lvl_raw), .q_o(lvl_q));

  gpio_rd_mux #(.NUM_PINS(NUM_PINS), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_rd (
    .addr_i(bus_addr_i), .out_i(out_q), .dir_i(dir_q), .lvl_i(lvl_q),
    .rdata_o(bus_rdata_o));
endmodule

// File: rtl/gpio_mwr_bank_chk.sv
module gpio_mwr_bank_chk
  import gpio_mwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [31:0]       pad_out_o,
  input logic [31:0]       pad_oe_o
);
  logic hit_half;
  assign hit_half = (bus_addr_i == ADDR_W'(OUT_BASE))     || (bus_addr_i == ADDR_W'(OUT_BASE + 4)) ||
                    (bus_addr_i == ADDR_W'(DIR_BASE))     || (bus_addr_i == ADDR_W'(DIR_BASE + 4));

  always @(posedge clk_i)
    if (!rst_ni) p_reset_clear_r1: assert (pad_out_o == '0 && pad_oe_o == '0);

  p_masked_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == ADDR_W'(OUT_BASE) |=>
    ((pad_out_o[15:0] ^ $past(pad_out_o[15:0])) & ~$past(bus_wdata_i[31:16])) == 16'h0);

  p_other_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == ADDR_W'(OUT_BASE) |=> $stable(pad_out_o[31:16]) && $stable(pad_oe_o));

  p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_half |-> bus_rdata_o[31:16] == 16'h0);

  p_no_effect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && hit_half) |=> $stable(pad_out_o) && $stable(pad_oe_o));

  p_ident_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == ADDR_W'(IDENT_ADDR) |-> bus_rdata_o == IDENT_VAL);
endmodule

bind gpio_mwr_bank gpio_mwr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o));

// File: tb/sim_gpio_mwr_bank.sv
`timescale 1ns/100ps
module sim_gpio_mwr_bank;
  logic        clk = 0, rst_n = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, pin = 0;
  logic [31:0] rdata, pout, poe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_mwr_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pin),
    .pad_out_o(pout), .pad_oe_o(poe));

  // behavioural reference
  bit [31:0] m_out, m_dir;
  bit [31:0] m_sync[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_sync = {32'h0, 32'h0};
    end else begin
      m_sync.push_back((m_dir & m_out) | (~m_dir & pin));
      void'(m_sync.pop_front());
      if (we) begin
        for (int b = 0; b < 16; b++) if (wdata[16+b]) begin
          case (addr)
            8'h00: m_out[b]    = wdata[b];
            8'h04: m_out[16+b] = wdata[b];
            8'h08: m_dir[b]    = wdata[b];
            8'h0C: m_dir[16+b] = wdata[b];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic bit [31:0] m_read(input bit [7:0] a);
    case (a)
      8'h00: return {16'h0, m_out[15:0]};
      8'h04: return {16'h0, m_out[31:16]};
      8'h08: return {16'h0, m_dir[15:0]};
      8'h0C: return {16'h0, m_dir[31:16]};
      8'h70: return m_sync[0];
      8'h78: return 32'h0101157C;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    check("R2 pad_out", pout, m_out);
    check("R4 pad_oe", poe, m_dir);
    case (addr)
      8'h70: check("R6 level read", rdata, m_read(addr));
      8'h78: check("R8 ident read", rdata, m_read(addr));
      8'h00, 8'h04, 8'h08, 8'h0C: check("R5 half read", rdata, m_read(addr));
      default: check("R9 unmapped read", rdata, m_read(addr));
    endcase
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1; we = 1; addr = a; wdata = d;
    @(negedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); #1; addr = a;
    @(negedge clk); d = rdata;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp_lvl;
    repeat (3) @(negedge clk);
    check("R1 reset pad_out", pout, 0);
    check("R1 reset pad_oe", poe, 0);
    #1 rst_n = 1;
    rd(8'h08, d); check("R1 reset dir read", d, 0);

    wr(8'h00, 32'hFFFF_A5A5);
    check("R10 out after strobe", pout, 32'h0000_A5A5);
    wr(8'h00, 32'h0001_0000);
    check("R2 clear single bit", pout, 32'h0000_A5A4);
    wr(8'h00, 32'h00F0_FFFF);
    check("R2 nibble enable", pout, 32'h0000_A5F4);
    wr(8'h04, 32'hFFFF_1234);
    check("R3 high half out", pout, 32'h1234_A5F4);
    wr(8'h0C, 32'h8001_FFFF);
    check("R3 high half dir", poe, 32'h8001_0000);
    wr(8'h08, 32'hFFFF_00FF);
    check("R4 low dir", poe, 32'h8001_00FF);
    repeat (2) @(negedge clk);
    check("R10 value holds", pout, 32'h1234_A5F4);
    rd(8'h04, d); check("R5 out high read", d, 32'h0000_1234);
    rd(8'h0C, d); check("R5 dir high read", d, 32'h0000_8001);

    // sync latency
    rd(8'h70, d);
    @(negedge clk); #1 pin = 32'h5555_AAAA;
    exp_lvl = (32'h8001_00FF & 32'h1234_A5F4) | (~32'h8001_00FF & 32'h5555_AAAA);
    @(negedge clk); check("R6 one edge old", rdata, d);
    @(negedge clk); check("R6 two edges new", rdata, exp_lvl);

    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    check("R7 out unchanged", pout, 32'h1234_A5F4);
    check("R7 oe unchanged", poe, 32'h8001_00FF);
    rd(8'h70, d); check("R7 level unchanged", d, exp_lvl);
    rd(8'h78, d); check("R8 ident", d, 32'h0101157C);
    rd(8'h10, d); check("R9 hole 0x10", d, 0);
    rd(8'h74, d); check("R9 hole 0x74", d, 0);
    rd(8'hFC, d); check("R9 hole 0xFC", d, 0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] sel [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h70, 8'h78, 8'h20, 8'h07};
      @(negedge clk); #1;
      we = $urandom_range(0, 1);
      addr = sel[$urandom_range(0, 7)];
      wdata = $urandom;
      if ($urandom_range(0, 3) == 0) pin = $urandom;
    end
    @(negedge clk); #1 we = 0;

    @(negedge clk); #1 rst_n = 0;
    @(negedge clk);
    check("R1 mid-run reset out", pout, 0);
    check("R1 mid-run reset oe", poe, 0);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule